// File: doc/BRIEF.md
# Pipelined CORDIC Square Root

This block returns the square root of a non-negative fixed-point sample. Every clock cycle it can take a new sample. The sample first passes through an even-count normalisation, which scales it into the range 0.5 to 2 by shifting left two bits at a time.

A hyperbolic-vectoring CORDIC then works on the normalised value using only shifts and adds:

- It starts from the pair (v + 0.25, v − 0.25).
- It drives the second coordinate to zero.
- The first coordinate ends up proportional to the square root of v.

A fixed shift-add correction removes the CORDIC gain. The result is then shifted right by half the normalisation shift and rounded. The output has the same word length and fraction length as the input.

A strobe travels with each sample. A synchronous restart flushes everything in flight. The parameter `ITER_PER_REG` sets how many iterations share one register stage. Raising it trades a longer combinational path for a shorter latency.

Top module: `cordic_sqrt`

## Requirements
- R1: A sample is accepted on every cycle with `in_valid` high, including back-to-back cycles. Each accepted sample yields exactly one single-cycle `out_valid` pulse, and results leave in the order the samples arrived.
- R2: The latency from an accepted sample to its `out_valid` is 2 + ceil(T / ITER_PER_REG) cycles. T is ceil(log2 DW) normalisation steps plus the CORDIC iteration count. The CORDIC count is the maximum shift plus one extra pass for each of the indices 4, 13, 40, … that does not exceed it. With DW = 16 and a maximum shift of 15, T = 4 + 17 = 21. The latency is then 23 cycles for ITER_PER_REG = 1, 13 cycles for 2, and 3 cycles for any value of 21 or more.
- R3: Data presented while `in_valid` is low has no effect on any output, and no result is produced for it.
- R4: When `restart` is high at a clock edge, every register is cleared. `out_valid` is low in the following cycle. No sample accepted up to and including that edge ever produces a result, even one that arrived together with `restart`.
- R5: While `rst` is high, and directly after it, `out_valid` and `out_data` are zero.
- R6: For a positive input code u (DW = 16 bits, FW = 10 fraction bits, two's complement), `out_data` is within 1 of round(sqrt(u · 2^FW)). That is the square root in the same Q5.10 format.
- R7: An input code of zero yields an output of exactly zero.
- R8: An input code with its sign bit (bit DW−1) set yields an output of exactly zero.
- R9: `out_data` is zero in every cycle in which `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| restart | input | 1 | Synchronous flush of all in-flight work |
| in_valid | input | 1 | Marks `in_data` as a sample to process |
| in_data | input | DW | Input code, signed, FW fraction bits |
| out_valid | output | 1 | One-cycle strobe marking a finished result |
| out_data | output | DW | Square root, same format as the input |

## Verification
Two events can meet in one cycle: a flush and a new sample, and in the same cycle results from earlier samples may be about to leave the pipeline. The bench runs a dense stream of back-to-back samples. It raises `restart` in a cycle that also carries a sample, then in a cycle that carries none, then again with the pipeline full. Three instances with 23-, 13- and 3-cycle latency are checked together. The bench keeps a history of every offered sample, marks as dead every sample at or before each restart, and expects a result exactly one latency after each surviving sample. It expects silence, with zero data, everywhere else.

// File: rtl/csqrt_pkg.sv
package csqrt_pkg;

    localparam int DW       = 16;                     // input/output word length
    localparam int FW       = 10;                     // fraction bits of input and output
    localparam int ODD      = (DW - 1 + FW) % 2;      // pad one MSB so the exponent halves evenly
    localparam int NW       = DW + ODD;               // normalisation frame width
    localparam int HALF_EXP = (NW - 1 + FW) / 2;      // output exponent for zero shift
    localparam int NSTEP    = $clog2(DW);             // normalisation steps
    localparam int JW       = NSTEP + 1;              // pair-shift counter width
    localparam int IW       = 32;                     // CORDIC datapath width
    localparam int IF       = 28;                     // CORDIC fraction bits
    localparam int GAIN_FB  = 30;                     // fraction bits of the gain constant

    localparam logic signed [IW-1:0] QUARTER = IW'(64'd1 << (IF - 2));

    typedef struct packed {
        logic                 vld;
        logic                 zero;
        logic [NW-1:0]        n;
        logic [JW-1:0]        j;
        logic signed [IW-1:0] x;
        logic signed [IW-1:0] y;
    } sq_state_t;

    // Indices 4, 13, 40, ... are run twice for hyperbolic convergence.
    function automatic bit is_repeat(int i);
        int r = 4;
        while (r <= i) begin
            if (r == i) return 1'b1;
            r = 3 * r + 1;
        end
        return 1'b0;
    endfunction

    function automatic int cordic_count(int m);
        int c = 0;
        for (int i = 1; i <= m; i++) c += is_repeat(i) ? 2 : 1;
        return c;
    endfunction

    // Shift index used by the k-th CORDIC iteration (0-based).
    function automatic int shift_at(int k);
        int c = 0;
        for (int i = 1; i <= 64; i++) begin
            if (c == k) return i;
            c++;
            if (is_repeat(i)) begin
                if (c == k) return i;
                c++;
            end
        end
        return 64;
    endfunction

    // Reciprocal of the hyperbolic gain, GAIN_FB fraction bits.
    function automatic longint inv_gain(int m);
        real k;
        k = 1.0;
        for (int i = 1; i <= m; i++) begin
            k = k * $sqrt(1.0 - 2.0 ** (-2.0 * i));
            if (is_repeat(i)) k = k * $sqrt(1.0 - 2.0 ** (-2.0 * i));
        end
        return longint'((2.0 ** GAIN_FB) / k);
    endfunction

    // One normalisation step: shift by 2^(b+1) bits if that many top bits are clear.
    function automatic sq_state_t norm_step(sq_state_t s, int b);
        sq_state_t     r = s;
        int            w = 2 << b;
        logic [NW-1:0] head;
        head = (w >= NW) ? s.n : (s.n >> (NW - w));
        if (head == '0) begin
            r.n = s.n << w;
            r.j = s.j + JW'(1 << b);
        end
        return r;
    endfunction

    function automatic sq_state_t cordic_step(sq_state_t s, int sh, bit first);
        sq_state_t            r = s;
        logic signed [IW-1:0] x, y, xs, ys, v;
        v = $signed(IW'(s.n) << (IF - NW + 1));
        x = first ? v + QUARTER : s.x;
        y = first ? v - QUARTER : s.y;
        xs = x >>> sh;
        ys = y >>> sh;
        if (y[IW-1]) begin
            r.x = x + ys;
            r.y = y + xs;
        end else begin
            r.x = x - ys;
            r.y = y - xs;
        end
        return r;
    endfunction

    function automatic sq_state_t step_at(sq_state_t s, int idx);
        if (idx < NSTEP) return norm_step(s, NSTEP - 1 - idx);
        return cordic_step(s, shift_at(idx - NSTEP), idx == NSTEP);
    endfunction

endpackage

// File: rtl/csqrt_prep.sv
module csqrt_prep
    import csqrt_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output sq_state_t     q
);

    logic non_pos;
    assign non_pos = in_data[DW-1] || (in_data == '0);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            q <= '0;
        end else begin
            q      <= '0;
            q.vld  <= in_valid;
            q.zero <= non_pos;
            q.n    <= non_pos ? '0 : NW'(in_data);
        end
    end

endmodule

// File: rtl/csqrt_stage.sv
module csqrt_stage
    import csqrt_pkg::*;
#(
    parameter int FIRST = 0,
    parameter int COUNT = 1,
    parameter int TOTAL = 1
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      clr,
    input  sq_state_t d,
    output sq_state_t q
);

    sq_state_t ch [COUNT+1];
    assign ch[0] = d;

    for (genvar t = 0; t < COUNT; t++) begin : g_it
        if (FIRST + t < TOTAL) begin : g_act
            assign ch[t+1] = step_at(ch[t], FIRST + t);
        end else begin : g_pass
            assign ch[t+1] = ch[t];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) q <= '0;
        else            q <= ch[COUNT];
    end

endmodule

// File: rtl/csqrt_finish.sv
module csqrt_finish
    import csqrt_pkg::*;
#(
    parameter longint INV_K = 64'd1 << GAIN_FB
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  sq_state_t     d,
    output logic          out_valid,
    output logic [DW-1:0] out_data
);

    logic signed [63:0] xe, acc, xc, rnd;
    int                 sh;

    // Gain removal as a sum of shifted copies, then denormalise and round.
    always_comb begin
        xe  = 64'(d.x);
        acc = '0;
        for (int b = 0; b < 63; b++) begin
            if (INV_K[b]) acc = acc + (xe <<< b);
        end
        xc  = acc >>> GAIN_FB;
        sh  = IF - HALF_EXP + int'(d.j);
        rnd = (xc + (64'sd1 <<< (sh - 1))) >>> sh;
    end

    logic unused_bits;
    assign unused_bits = ^{d.n, d.y, acc[GAIN_FB-1:0], rnd[63:DW]};

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= d.vld;
            out_data  <= (d.vld && !d.zero) ? rnd[DW-1:0] : '0;
        end
    end

endmodule

// File: rtl/cordic_sqrt.sv
module cordic_sqrt
    import csqrt_pkg::*;
#(
    parameter int ITER_PER_REG = 1,
    parameter int MAX_SHIFT    = DW - 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic          out_valid,
    output logic [DW-1:0] out_data
);

    localparam int     NCORD = cordic_count(MAX_SHIFT);
    localparam int     TOTAL = NSTEP + NCORD;
    localparam int     NSTG  = (TOTAL + ITER_PER_REG - 1) / ITER_PER_REG;
    localparam longint INV_K = inv_gain(MAX_SHIFT);

    sq_state_t pipe [NSTG+1];

    csqrt_prep u_prep (
        .clk      (clk),
        .rst      (rst),
        .clr      (restart),
        .in_valid (in_valid),
        .in_data  (in_data),
        .q        (pipe[0])
    );

    for (genvar s = 0; s < NSTG; s++) begin : g_stg
        csqrt_stage #(
            .FIRST (s * ITER_PER_REG),
            .COUNT (ITER_PER_REG),
            .TOTAL (TOTAL)
        ) u_stg (
            .clk (clk),
            .rst (rst),
            .clr (restart),
            .d   (pipe[s]),
            .q   (pipe[s+1])
        );
    end

    csqrt_finish #(
        .INV_K (INV_K)
    ) u_fin (
        .clk       (clk),
        .rst       (rst),
        .clr       (restart),
        .d         (pipe[NSTG]),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

endmodule

// File: rtl/csqrt_chk.sv
module csqrt_chk
    import csqrt_pkg::*;
#(
    parameter int ITER_PER_REG = 1,
    parameter int MAX_SHIFT    = DW - 1
) (
    input logic          clk,
    input logic          rst,
    input logic          restart,
    input logic          in_valid,
    input logic [DW-1:0] in_data,
    input logic          out_valid,
    input logic [DW-1:0] out_data
);

    localparam int ITERS = $clog2(DW) + cordic_count(MAX_SHIFT);
    localparam int LAT   = 2 + (ITERS + ITER_PER_REG - 1) / ITER_PER_REG;

    logic [LAT-1:0] vsr, zsr;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            vsr <= '0;
            zsr <= '0;
        end else begin
            vsr <= {vsr[LAT-2:0], in_valid};
            zsr <= {zsr[LAT-2:0], in_data[DW-1] || (in_data == '0)};
        end
    end

    // R1, R2, R3: strobe appears exactly LAT cycles after each accepted sample
    assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid == vsr[LAT-1]);

    assert_flush_R4: assert property (@(posedge clk) disable iff (rst)
        restart |=> !out_valid);

    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_data == '0));

    // R7 and R8: non-positive input gives exactly zero
    assert_nonpos_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && zsr[LAT-1]) |-> (out_data == '0));

    assert_result_sign_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !out_data[DW-1]);

endmodule

bind cordic_sqrt csqrt_chk #(
    .ITER_PER_REG (ITER_PER_REG),
    .MAX_SHIFT    (MAX_SHIFT)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .restart   (restart),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/cordic_sqrt_tb.sv
module cordic_sqrt_tb;
    import csqrt_pkg::*;

    localparam int ITERS = 21;
    localparam int IPR_A = 1;
    localparam int IPR_B = 2;
    localparam int IPR_C = 32;
    localparam int LAT_A = 2 + (ITERS + IPR_A - 1) / IPR_A;  // 23
    localparam int LAT_B = 2 + (ITERS + IPR_B - 1) / IPR_B;  // 13
    localparam int LAT_C = 2 + (ITERS + IPR_C - 1) / IPR_C;  // 3

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          restart = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          ov_a, ov_b, ov_c;
    logic [DW-1:0] od_a, od_b, od_c;

    always #4ns clk = ~clk;

    cordic_sqrt #(.ITER_PER_REG(IPR_A)) u_dut (
        .clk(clk), .rst(rst), .restart(restart), .in_valid(in_valid),
        .in_data(in_data), .out_valid(ov_a), .out_data(od_a));
    cordic_sqrt #(.ITER_PER_REG(IPR_B)) u_dut_b (
        .clk(clk), .rst(rst), .restart(restart), .in_valid(in_valid),
        .in_data(in_data), .out_valid(ov_b), .out_data(od_b));
    cordic_sqrt #(.ITER_PER_REG(IPR_C)) u_dut_c (
        .clk(clk), .rst(rst), .restart(restart), .in_valid(in_valid),
        .in_data(in_data), .out_valid(ov_c), .out_data(od_c));

    bit            hv [65536];
    logic [DW-1:0] hd [65536];
    int            m = 0;
    int            nchk = 0;
    int            nfail = 0;
    string         ph = "R5";

    function automatic int ref_sqrt(int u);
        longint p = longint'(u) << FW;
        longint r = 0;
        for (longint b = 64'sd1 << 16; b > 0; b = b >> 1) begin
            if ((r + b) * (r + b) <= p) r = r + b;
        end
        if (p - r * r > r) r = r + 1;
        return int'(r);
    endfunction

    task automatic chk(input int idx, input int lat, input logic v, input logic [DW-1:0] d);
        bit    ev;
        int    u, e, g;
        string tg;
        ev = 1'b0;
        if (m >= lat) ev = hv[m-lat];
        nchk++;
        if (v !== ev) begin
            nfail++;
            $display("FAIL %s dut%0d out_valid got %0b exp %0b cycle %0d", ph, idx, v, ev, m);
        end else if (!ev) begin
            if (d !== '0) begin
                nfail++;
                tg = (ph == "R5") ? "R5" : "R9";
                $display("FAIL %s dut%0d idle out_data got %0d exp 0 cycle %0d", tg, idx, d, m);
            end
        end else begin
            u = int'($signed(hd[m-lat]));
            g = int'(d);
            if (u <= 0) begin
                tg = (u == 0) ? "R7" : "R8";
                if (g != 0) begin
                    nfail++;
                    $display("FAIL %s dut%0d in %0d got %0d exp 0", tg, idx, u, g);
                end
            end else begin
                e = ref_sqrt(u);
                if (g - e > 1 || e - g > 1) begin
                    nfail++;
                    $display("FAIL R6 dut%0d in %0d got %0d exp %0d", idx, u, g, e);
                end
            end
        end
    endtask

    task automatic cyc(input bit r, input bit v, input logic [DW-1:0] d, input bit rs);
        @(negedge clk);
        chk(0, LAT_A, ov_a, od_a);
        chk(1, LAT_B, ov_b, od_b);
        chk(2, LAT_C, ov_c, od_c);
        rst      = r;
        in_valid = v;
        in_data  = d;
        restart  = rs;
        hv[m] = v && !rs && !r;
        hd[m] = d;
        if (rs || r) begin
            for (int k = m; k >= 0 && k > m - 30; k--) hv[k] = 1'b0;
        end
        m++;
    endtask

    initial begin
        // R5: reset state
        ph = "R5";
        for (int i = 0; i < 6; i++) cyc(1'b1, 1'b0, '0, 1'b0);
        // R1, R6, R7: every non-negative code back to back
        ph = "R1";
        for (int i = 0; i < 32768; i++) cyc(1'b0, 1'b1, DW'(i), 1'b0);
        ph = "R2";
        for (int i = 0; i < 30; i++) cyc(1'b0, 1'b0, '0, 1'b0);
        // R8: sign bit set
        ph = "R8";
        for (int i = 0; i < 64; i++) cyc(1'b0, 1'b1, DW'(16'h8000 | ((i * 511) & 16'h7fff)), 1'b0);
        cyc(1'b0, 1'b1, 16'hffff, 1'b0);
        // R3: gapped stream with data changing while in_valid is low
        ph = "R3";
        for (int i = 0; i < 2000; i++)
            cyc(1'b0, (i % 3) != 1, DW'((i * 40503 + 17) & 16'h7fff), 1'b0);
        ph = "R2";
        for (int i = 0; i < 30; i++) cyc(1'b0, 1'b0, DW'(i * 3), 1'b0);
        // R4: restart with a sample, without one, and with a full pipeline
        ph = "R4";
        for (int i = 0; i < 200; i++)
            cyc(1'b0, i != 51, DW'((i * 97 + 5) & 16'h7fff), i == 50 || i == 51 || i == 120);
        ph = "R2";
        for (int i = 0; i < 30; i++) cyc(1'b0, 1'b0, '0, 1'b0);
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL R1 watchdog got hang exp completion");
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule